// File: doc/BRIEF.md
# Cascadable Dual Interval Timer

Two down-counting interval timers, A and B, each as wide as two bytes, sit behind a byte-wide register interface. Each timer has a reload latch that is written one byte at a time, a live counter that can be read back one byte at a time, and a control register. Either timer can run continuously or stop itself after one underflow. A force-load strobe copies the latch into the counter. Each timer emits a one-cycle underflow strobe for an interrupt controller. Each timer can also replace one port bit with its output, either as a one-cycle pulse at underflow or as a level that toggles at each underflow.

Timer B picks its count event through two control bits: every system clock, every timer A underflow, or every cycle in which the external count strobe is high. The external strobe is taken as already synchronised and filtered. Start, stop and force-load each have a fixed cycle latency. These latencies come from a per-timer state machine:
- T_IDLE: the counter holds.
- T_LOADWAIT: one dead cycle after a start combined with force-load.
- T_START: one dead cycle after any start.
- T_RUN: the counter counts.
- T_COAST: the single extra count after a stop.

The state machine has these transitions:
- T_IDLE or T_COAST to T_START on a start write.
- T_IDLE or T_COAST to T_LOADWAIT on a start write with force-load.
- T_LOADWAIT to T_START after one cycle.
- T_START to T_RUN after one cycle.
- Any counting state to T_LOADWAIT on a force-load write that keeps the run bit set.
- Any counting state to T_COAST on a stop write.
- Any counting state to T_IDLE on a stop write with force-load.
- T_RUN to T_IDLE on a one-shot underflow.
- T_COAST to T_IDLE after one cycle.

Register offsets on the 3-bit address:
- 0: A low byte (latch on write, counter on read).
- 1: A high byte.
- 2: B low byte.
- 3: B high byte.
- 4: A control.
- 5: B control.
- 6 and 7: read as 0, writes ignored.

Control bits:
- Bit 0: run.
- Bit 1: port-bit enable.
- Bit 2: toggle (1) or pulse (0) output.
- Bit 3: one-shot.
- Bit 4: force-load strobe.
- Bits 6:5: timer B source.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counters and both latches hold 0xFFFF, both control registers read 0x00, and no underflow strobe or port-bit enable is active.
- R2: A write to a high byte (offset 1 or 3) while the timer is stopped loads the counter with {written byte, latch low byte}. A low-byte write changes only the latch.
- R3: In continuous mode (bit 3 = 0), underflow strobes come every latch+1 count events, and the counter reads the latch value in the cycle of the strobe.
- R4: A start write (bit 0 = 1) on a stopped timer with counter value C gives the first underflow strobe C+2 cycles after the clock edge that takes the write. With bit 4 also set, the counter is loaded with the latch L and the strobe comes at L+3.
- R5: In one-shot mode (bit 3 = 1), the underflow clears control bit 0, and the counter then holds the latch value with no further strobes.
- R6: Writing control bit 4 copies the latch into the counter at the next edge, and bit 4 always reads back as 0.
- R7: A stop write (bit 0 = 0) on a counting timer lets the counter count at the write edge and once more at the following edge. With bit 4 set in the same write, the counter is loaded with the latch and then holds.
- R8: Control bit 1 drives port bit 6 (timer A) or port bit 7 (timer B) with the timer output. Bit 2 = 1 selects a level that is set to 1 when the timer starts and inverts at each underflow. Bit 2 = 0 selects a copy of the one-cycle underflow strobe.
- R9: Timer B bits 6:5 select its count event: 00 every system clock, 10 each timer A underflow strobe, 01 or 11 each cycle with the external count strobe high.
- R10: With timer B source 10, timer B decrements exactly once per timer A underflow and holds its count in cycles without one.
- R11: Reads of offsets 0 to 3 return the live counter bytes, not the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 8 | Register read data (combinational) |
| ext_cnt | input | 1 | External count strobe, one count per high cycle |
| a_uflow | output | 1 | Timer A underflow strobe |
| b_uflow | output | 1 | Timer B underflow strobe |
| port_b6_out | output | 1 | Timer A output value for port bit 6 |
| port_b6_take | output | 1 | Port bit 6 is replaced by timer A output |
| port_b7_out | output | 1 | Timer B output value for port bit 7 |
| port_b7_take | output | 1 | Port bit 7 is replaced by timer B output |

## Verification
The bench builds the block with its default byte width of 8, which gives 16-bit counters and matches the byte-wide register map. The bench programs small latch values through the byte interface, so underflow periods of a few cycles are reached at once. These short periods put the start, force-load, stop and one-shot latencies within reach of cycle-exact checks. The 0xFFFF reset values are checked by reading the counters back rather than by waiting out a full period.

// File: rtl/dit_pkg.sv
package dit_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [2:0] {
        T_IDLE,
        T_LOADWAIT,
        T_START,
        T_RUN,
        T_COAST
    } tmr_state_e;

    localparam int CB_START   = 0;
    localparam int CB_PIN_EN  = 1;
    localparam int CB_TOGGLE  = 2;
    localparam int CB_ONESHOT = 3;
    localparam int CB_FORCE   = 4;
    localparam int CB_SRC_LO  = 5;
    localparam int CB_SRC_HI  = 6;

    localparam logic [ADDR_W-1:0] ADR_A_LO  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_A_HI  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_B_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_B_HI  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CTL_A = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_CTL_B = 3'd5;
endpackage

// File: rtl/dit_tick_sel.sv
module dit_tick_sel (
    input  logic [1:0] src,
    input  logic       a_uflow,
    input  logic       ext_pulse,
    output logic       tick
);
    // 00: system clock, 10: timer A underflows, x1: external strobe
    always_comb begin
        unique case (src)
            2'b00:   tick = 1'b1;
            2'b10:   tick = a_uflow;
            default: tick = ext_pulse;
        endcase
    end
endmodule

// File: rtl/dit_pin.sv
module dit_pin (
    input  logic en,
    input  logic mode_toggle,
    input  logic uflow,
    input  logic tog,
    output logic val,
    output logic take
);
    assign take = en;
    assign val  = en & (mode_toggle ? tog : uflow);
endmodule

// File: rtl/dit_timer.sv
module dit_timer
    import dit_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lo_we,
    input  logic                  hi_we,
    input  logic                  ctl_we,
    input  logic [BYTE_W-1:0]     wdata,
    input  logic                  tick,
    output logic [2*BYTE_W-1:0]   cnt,
    output logic [2*BYTE_W-1:0]   latch,
    output logic [BYTE_W-1:0]     ctrl,
    output logic                  uflow,
    output logic                  tog
);
    localparam int CNT_W = 2 * BYTE_W;
    localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);
    localparam logic [BYTE_W-1:0] KEEPMASK = ~(BYTE_W'(1) << CB_FORCE);

    tmr_state_e state_q, state_d;
    logic start_req, stop_req, force_req, stopped, uf_evt;

    assign start_req = ctl_we &  wdata[CB_START];
    assign stop_req  = ctl_we & ~wdata[CB_START];
    assign force_req = ctl_we &  wdata[CB_FORCE];
    assign stopped   = (state_q == T_IDLE) || (state_q == T_COAST);
    assign uf_evt    = (state_q == T_RUN) && tick && (cnt == '0) && !force_req;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= T_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_IDLE, T_COAST: begin
                if (start_req) state_d = force_req ? T_LOADWAIT : T_START;
                else           state_d = T_IDLE;
            end
            T_LOADWAIT: begin
                if (stop_req)       state_d = force_req ? T_IDLE : T_COAST;
                else if (force_req) state_d = T_LOADWAIT;
                else                state_d = T_START;
            end
            T_START: begin
                if (stop_req)       state_d = force_req ? T_IDLE : T_COAST;
                else if (force_req) state_d = T_LOADWAIT;
                else                state_d = T_RUN;
            end
            T_RUN: begin
                if (stop_req)       state_d = force_req ? T_IDLE : T_COAST;
                else if (force_req) state_d = T_LOADWAIT;
                else if (uf_evt && ctrl[CB_ONESHOT] && !ctl_we)
                                    state_d = T_IDLE;
                else                state_d = T_RUN;
            end
            default: state_d = T_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '1;
            latch <= '1;
            ctrl  <= '0;
            uflow <= 1'b0;
            tog   <= 1'b0;
        end else begin
            if (lo_we) latch[BYTE_W-1:0]     <= wdata;
            if (hi_we) latch[CNT_W-1:BYTE_W] <= wdata;

            if (force_req)
                cnt <= latch;
            else if (hi_we && stopped)
                cnt <= {wdata, latch[BYTE_W-1:0]};
            else if (state_q == T_RUN && tick)
                cnt <= (cnt == '0) ? latch : cnt - ONE;
            else if (state_q == T_COAST && tick && cnt != '0)
                cnt <= cnt - ONE;

            if (ctl_we)
                ctrl <= wdata & KEEPMASK;
            else if (uf_evt && ctrl[CB_ONESHOT])
                ctrl[CB_START] <= 1'b0;

            uflow <= uf_evt;

            if (ctl_we && wdata[CB_START] && !ctrl[CB_START])
                tog <= 1'b1;
            else if (uf_evt)
                tog <= ~tog;
        end
    end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              ext_cnt,
    output logic              a_uflow,
    output logic              b_uflow,
    output logic              port_b6_out,
    output logic              port_b6_take,
    output logic              port_b7_out,
    output logic              port_b7_take
);
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int N_TMR  = 2;

    logic [CNT_W-1:0]  cnt_q   [N_TMR];
    logic [CNT_W-1:0]  latch_q [N_TMR];
    logic [BYTE_W-1:0] ctrl_q  [N_TMR];
    logic              uflow_q [N_TMR];
    logic              tog_q   [N_TMR];
    logic              pin_val [N_TMR];
    logic              pin_take[N_TMR];

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        logic tick_i;
        if (i == 0) begin : g_clk
            assign tick_i = 1'b1;
        end else begin : g_sel
            dit_tick_sel u_sel (
                .src      (ctrl_q[i][CB_SRC_HI:CB_SRC_LO]),
                .a_uflow  (uflow_q[0]),
                .ext_pulse(ext_cnt),
                .tick     (tick_i)
            );
        end

        dit_timer #(.BYTE_W(BYTE_W)) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .lo_we (wr_en && wr_addr == ADDR_W'(2 * i)),
            .hi_we (wr_en && wr_addr == ADDR_W'(2 * i + 1)),
            .ctl_we(wr_en && wr_addr == ADDR_W'(4 + i)),
            .wdata (wr_data),
            .tick  (tick_i),
            .cnt   (cnt_q[i]),
            .latch (latch_q[i]),
            .ctrl  (ctrl_q[i]),
            .uflow (uflow_q[i]),
            .tog   (tog_q[i])
        );

        dit_pin u_pin (
            .en         (ctrl_q[i][CB_PIN_EN]),
            .mode_toggle(ctrl_q[i][CB_TOGGLE]),
            .uflow      (uflow_q[i]),
            .tog        (tog_q[i]),
            .val        (pin_val[i]),
            .take       (pin_take[i])
        );
    end

    assign a_uflow      = uflow_q[0];
    assign b_uflow      = uflow_q[1];
    assign port_b6_out  = pin_val[0];
    assign port_b6_take = pin_take[0];
    assign port_b7_out  = pin_val[1];
    assign port_b7_take = pin_take[1];

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_A_LO:  rd_data = cnt_q[0][BYTE_W-1:0];
            ADR_A_HI:  rd_data = cnt_q[0][CNT_W-1:BYTE_W];
            ADR_B_LO:  rd_data = cnt_q[1][BYTE_W-1:0];
            ADR_B_HI:  rd_data = cnt_q[1][CNT_W-1:BYTE_W];
            ADR_CTL_A: rd_data = ctrl_q[0];
            ADR_CTL_B: rd_data = ctrl_q[1];
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dit_checker.sv
module dit_checker
    import dit_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic                wr_start,
    input logic                wr_force,
    input logic [2*BYTE_W-1:0] cnt_a,
    input logic [2*BYTE_W-1:0] latch_a,
    input logic                ctrl_a_start,
    input logic                ctrl_a_oneshot,
    input logic                tog_a,
    input logic                a_uflow,
    input logic [1:0]          src_b,
    input logic [2*BYTE_W-1:0] cnt_b
);
    assert_force_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_CTL_A && wr_force) |=> (cnt_a == $past(latch_a)));

    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_uflow && !$past(wr_en)) |-> (cnt_a == latch_a));

    assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_uflow && $past(ctrl_a_oneshot) && !$past(wr_en)) |-> !ctrl_a_start);

    assert_chain_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && src_b == 2'b10 && !a_uflow) |=> $stable(cnt_b));

    assert_start_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_CTL_A && wr_start && !ctrl_a_start) |=> tog_a);
endmodule

bind dual_interval_timer dit_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_start      (wr_data[0]),
    .wr_force      (wr_data[4]),
    .cnt_a         (cnt_q[0]),
    .latch_a       (latch_q[0]),
    .ctrl_a_start  (ctrl_q[0][0]),
    .ctrl_a_oneshot(ctrl_q[0][3]),
    .tog_a         (tog_q[0]),
    .a_uflow       (uflow_q[0]),
    .src_b         (ctrl_q[1][6:5]),
    .cnt_b         (cnt_q[1])
);

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
    import dit_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, wr_en, ext_cnt;
    logic [2:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic a_uflow, b_uflow, port_b6_out, port_b6_take, port_b7_out, port_b7_take;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    dual_interval_timer u_dual_interval_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ext_cnt(ext_cnt),
        .a_uflow(a_uflow), .b_uflow(b_uflow),
        .port_b6_out(port_b6_out), .port_b6_take(port_b6_take),
        .port_b7_out(port_b7_out), .port_b7_take(port_b7_take)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; ext_cnt = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd8(input logic [2:0] a, output int v);
        rd_addr = a; #1; v = int'(rd_data);
    endtask

    task automatic rd16(input logic [2:0] lo, output int v);
        int l, h;
        rd8(lo, l);
        rd8(lo + 3'd1, h);
        v = h * 256 + l;
    endtask

    task automatic cycles(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wait_uf(input bit sel_b, output int n);
        n = 0;
        while (n < 5000) begin
            @(posedge clk); n++; @(negedge clk);
            if ((sel_b ? b_uflow : a_uflow) == 1'b1) break;
        end
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        rd16(ADR_A_LO, v); check("R1 A counter", v, 16'hFFFF);
        rd16(ADR_B_LO, v); check("R1 B counter", v, 16'hFFFF);
        rd8(ADR_CTL_A, v); check("R1 A control", v, 0);
        rd8(ADR_CTL_B, v); check("R1 B control", v, 0);
        check("R1 strobes", int'(a_uflow) + int'(b_uflow), 0);
        check("R1 pin enables", int'(port_b6_take) + int'(port_b7_take), 0);
        wr(ADR_CTL_A, 8'h10);
        rd16(ADR_A_LO, v); check("R1 latch reset value", v, 16'hFFFF);
    endtask

    task automatic t_latch();
        int v;
        do_reset();
        wr(ADR_A_LO, 8'h20);
        rd16(ADR_A_LO, v); check("R2 low write leaves counter", v, 16'hFFFF);
        wr(ADR_A_HI, 8'h01);
        rd16(ADR_A_LO, v); check("R2 high write loads counter", v, 16'h0120);
        wr(ADR_A_LO, 8'h07);
        rd16(ADR_A_LO, v); check("R11 reads counter not latch", v, 16'h0120);
        wr(ADR_CTL_A, 8'h10);
        rd16(ADR_A_LO, v); check("R6 force-load copies latch", v, 16'h0107);
        rd8(ADR_CTL_A, v); check("R6 strobe reads 0", v, 0);
    endtask

    task automatic t_start();
        int n, v;
        do_reset();
        wr(ADR_A_LO, 8'd5); wr(ADR_A_HI, 8'd0);
        wr(ADR_CTL_A, 8'h01);
        wait_uf(1'b0, n); check("R4 start latency", n, 7);
        rd16(ADR_A_LO, v); check("R3 reload at underflow", v, 5);
        wait_uf(1'b0, n); check("R3 continuous period", n, 6);
        do_reset();
        wr(ADR_A_LO, 8'd5); wr(ADR_A_HI, 8'd0);
        wr(ADR_CTL_A, 8'h11);
        wait_uf(1'b0, n); check("R4 start with force-load", n, 8);
        do_reset();
        wr(ADR_B_LO, 8'd3); wr(ADR_B_HI, 8'd0);
        wr(ADR_CTL_B, 8'h01);
        wait_uf(1'b1, n); check("R9 B clock source latency", n, 5);
    endtask

    task automatic t_stop();
        int v;
        do_reset();
        wr(ADR_A_LO, 8'd100); wr(ADR_A_HI, 8'd0);
        wr(ADR_CTL_A, 8'h01);
        cycles(10);
        rd16(ADR_A_LO, v); check("R11 live count", v, 91);
        wr(ADR_CTL_A, 8'h00);
        cycles(1);
        rd16(ADR_A_LO, v); check("R7 one count after stop", v, 89);
        cycles(5);
        rd16(ADR_A_LO, v); check("R7 holds after stop", v, 89);
        do_reset();
        wr(ADR_A_LO, 8'd100); wr(ADR_A_HI, 8'd0);
        wr(ADR_CTL_A, 8'h01);
        cycles(10);
        wr(ADR_CTL_A, 8'h10);
        cycles(3);
        rd16(ADR_A_LO, v); check("R7 stop with force-load", v, 100);
    endtask

    task automatic t_oneshot();
        int n, v, extra;
        do_reset();
        wr(ADR_A_LO, 8'd4); wr(ADR_A_HI, 8'd0);
        wr(ADR_CTL_A, 8'h09);
        wait_uf(1'b0, n); check("R5 one-shot latency", n, 6);
        rd8(ADR_CTL_A, v); check("R5 run bit cleared", v, 8'h08);
        extra = 0;
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); @(negedge clk);
            if (a_uflow) extra++;
        end
        check("R5 no further underflow", extra, 0);
        rd16(ADR_A_LO, v); check("R5 counter holds latch", v, 4);
    endtask

    task automatic t_pins();
        int n;
        do_reset();
        wr(ADR_A_LO, 8'd5); wr(ADR_A_HI, 8'd0);
        wr(ADR_CTL_A, 8'h07);
        check("R8 toggle set at start", int'(port_b6_out), 1);
        check("R8 port bit 6 taken", int'(port_b6_take), 1);
        wait_uf(1'b0, n);
        check("R8 toggle flips", int'(port_b6_out), 0);
        wait_uf(1'b0, n);
        check("R8 toggle flips back", int'(port_b6_out), 1);
        do_reset();
        wr(ADR_A_LO, 8'd5); wr(ADR_A_HI, 8'd0);
        wr(ADR_CTL_A, 8'h03);
        check("R8 pulse idle low", int'(port_b6_out), 0);
        wait_uf(1'b0, n);
        check("R8 pulse at underflow", int'(port_b6_out), 1);
        cycles(1);
        check("R8 pulse one cycle", int'(port_b6_out), 0);
        wr(ADR_CTL_A, 8'h05);
        check("R8 bit 1 clear releases port bit", int'(port_b6_take), 0);
        wr(ADR_CTL_B, 8'h07);
        check("R8 B toggle on port bit 7", int'(port_b7_out) + int'(port_b7_take), 2);
    endtask

    task automatic t_chain();
        int v, acount, at_b;
        do_reset();
        wr(ADR_B_LO, 8'd2); wr(ADR_B_HI, 8'd0);
        wr(ADR_CTL_B, 8'h41);
        cycles(5);
        rd16(ADR_B_LO, v); check("R10 no clock counting", v, 2);
        wr(ADR_A_LO, 8'd3); wr(ADR_A_HI, 8'd0);
        wr(ADR_CTL_A, 8'h01);
        acount = 0; at_b = -1;
        for (int k = 0; k < 60 && at_b < 0; k++) begin
            @(posedge clk); @(negedge clk);
            if (b_uflow) at_b = acount;
            if (a_uflow) begin
                acount++;
                if (acount == 1) begin
                    @(posedge clk); @(negedge clk);
                    rd16(ADR_B_LO, v); check("R10 one count per A underflow", v, 1);
                end
            end
        end
        check("R9 B underflows on third A underflow", at_b, 3);
        rd16(ADR_B_LO, v); check("R10 B reload", v, 2);
    endtask

    task automatic t_ext();
        int v;
        do_reset();
        wr(ADR_B_LO, 8'd1); wr(ADR_B_HI, 8'd0);
        wr(ADR_CTL_B, 8'h21);
        cycles(5);
        rd16(ADR_B_LO, v); check("R9 ext source ignores clock", v, 1);
        ext_cnt = 1'b1; @(posedge clk); @(negedge clk); ext_cnt = 1'b0;
        rd16(ADR_B_LO, v); check("R9 ext strobe counts", v, 0);
        ext_cnt = 1'b1; @(posedge clk); @(negedge clk); ext_cnt = 1'b0;
        check("R9 ext underflow", int'(b_uflow), 1);
        wr(ADR_CTL_B, 8'h61);
        cycles(4);
        rd16(ADR_B_LO, v); check("R9 source 11 ignores clock", v, 1);
        ext_cnt = 1'b1; @(posedge clk); @(negedge clk); ext_cnt = 1'b0;
        rd16(ADR_B_LO, v); check("R9 source 11 counts strobe", v, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latch();
        t_start();
        t_stop();
        t_oneshot();
        t_pins();
        t_chain();
        t_ext();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule